// File: doc/BRIEF.md
# Event Performance Monitor Unit

A small performance monitor that counts clock cycles in one counter and selected events in two more. Each event input is a single-cycle pulse on one bit of an event vector. A configurable counter picks the bit it follows with an 8-bit code held in a shared control word. A simple register port with a two-bit address reaches four words: control at 0, the cycle count at 1, event counter 0 at 2 and event counter 1 at 3. Every counter can be loaded directly, and loading zero serves as a per-counter reset.

The configurable counters have no enable of their own. Software parks a counter by selecting a code whose input stays low, such as the external trace code 0x20, or a code above the event vector's width. The cycle counter runs whenever the global enable is set, optionally divided by a prescaler. Each counter has an overflow flag in the control word, set when it wraps and cleared by writing a one to it. One interrupt output combines the three flags through their enable bits.

Top module: `evmon_unit`

## Requirements
- R1: After reset all three counters read 0, the control word reads 0 and irq is low.
- R2: While control bit 0 (global enable) is 0, no counter changes except through a register write.
- R3: With bit 0 set, counter 0 adds one in every cycle where the event input selected by control bits 27:20 is high, and counter 1 does the same for bits 19:12. A code with no matching input (>= the event vector width), or one whose input stays low (0x20 held idle), leaves the counter unchanged.
- R4: With bit 0 set and bit 3 clear, the cycle counter adds one every clock. With bit 3 set it adds one every PRESCALE clocks, the first time on the PRESCALE-th clock after its reset.
- R5: A write to address 1, 2 or 3 loads the cycle counter, counter 0 or counter 1 on that edge, and the written value wins over an increment in the same cycle.
- R6: Writing control with bit 1 set zeroes both configurable counters, and with bit 2 set zeroes the cycle counter and its prescaler. Bits 1 and 2 always read back 0.
- R7: A counter that increments from 0xFFFFFFFF reads 0 and sets its overflow flag on the same edge: control bit 8 for counter 0, bit 9 for counter 1, bit 10 for the cycle counter.
- R8: An overflow flag stays set until a control write carries a 1 in its bit. Writing 0 there leaves it unchanged. A wrap in the same cycle as the clear keeps it set.
- R9: irq is high exactly when some overflow flag is set together with its enable: bit 4 for counter 0, bit 5 for counter 1, bit 6 for the cycle counter.
- R10: The control word reads back the global enable (bit 0), prescaler enable (bit 3), interrupt enables (6:4), flags (10:8) and the two selectors (27:20, 19:12), with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 cycle, 2 counter 0, 3 counter 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | EVT_W | Event pulses, bit n is event code n |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The bench builds the unit with a 48-bit event vector and a prescaler of 8. The wider vector makes code 0x20 a real input that can be held idle while every other event fires, and it leaves codes such as 0xFF beyond the vector to show that an unmatched code freezes a counter. The short prescaler brings several divided cycle-counter steps within a few dozen clocks. Wraps are reached by loading counters just below all ones, and they are then checked against flag, clear and interrupt behaviour.

// File: rtl/evmon_unit.sv
module evmon_unit #(
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 48,
  parameter int PRESCALE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EVT_W-1:0] evt_in,
  output logic             irq
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic             run, div;
  logic [2:0]       ien, ovf;
  logic [7:0]       sel0, sel1;
  logic [CNT_W-1:0] cyc, c0, c1;
  logic [PW-1:0]    pre;
  logic [255:0]     evt_ext;

  assign evt_ext = 256'(evt_in);

  wire ctl_we  = reg_we && (reg_addr == 2'd0);
  wire ld_cyc  = reg_we && (reg_addr == 2'd1);
  wire ld0     = reg_we && (reg_addr == 2'd2);
  wire ld1     = reg_we && (reg_addr == 2'd3);
  wire clr_ev  = ctl_we && reg_wdata[1];
  wire clr_cyc = ctl_we && reg_wdata[2];

  wire tick = run && (!div || (pre == PRE_LAST));
  wire inc0 = run && evt_ext[sel0];
  wire inc1 = run && evt_ext[sel1];

  wire [2:0] wrap = {tick && (&cyc) && !clr_cyc && !ld_cyc,
                     inc1 && (&c1)  && !clr_ev  && !ld1,
                     inc0 && (&c0)  && !clr_ev  && !ld0};
  wire [2:0] clr_flag = ctl_we ? reg_wdata[10:8] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      div  <= 1'b0;
      ien  <= '0;
      sel0 <= '0;
      sel1 <= '0;
      ovf  <= '0;
    end else begin
      if (ctl_we) begin
        run  <= reg_wdata[0];
        div  <= reg_wdata[3];
        ien  <= reg_wdata[6:4];
        sel0 <= reg_wdata[27:20];
        sel1 <= reg_wdata[19:12];
      end
      ovf <= (ovf & ~clr_flag) | wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (clr_cyc)       pre <= '0;
    else if (run && div)    pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc <= '0;
    else if (clr_cyc) cyc <= '0;
    else if (ld_cyc)  cyc <= reg_wdata[CNT_W-1:0];
    else if (tick)    cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      c0 <= '0;
    else if (clr_ev) c0 <= '0;
    else if (ld0)    c0 <= reg_wdata[CNT_W-1:0];
    else if (inc0)   c0 <= c0 + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      c1 <= '0;
    else if (clr_ev) c1 <= '0;
    else if (ld1)    c1 <= reg_wdata[CNT_W-1:0];
    else if (inc1)   c1 <= c1 + 1'b1;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, sel0, sel1, 1'b0, ovf, 1'b0, ien, div, 2'b0, run};
      2'd1:    reg_rdata = 32'(cyc);
      2'd2:    reg_rdata = 32'(c0);
      default: reg_rdata = 32'(c1);
    endcase
  end

  assign irq = |(ovf & ien);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_we) |=> ($stable(c0) && $stable(c1) && $stable(cyc)));

  p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div && !clr_cyc && !ld_cyc) |=> (cyc == $past(cyc) + 1'b1));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> (c0 == $past(reg_wdata[CNT_W-1:0])));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (c0 == '0 && c1 == '0));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc0 && (&c0) && !clr_ev && !ld0) |=> (c0 == '0 && ovf[0]));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && !(ctl_we && reg_wdata[9])) |=> ovf[1]);

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && reg_wdata[6:4] == 3'b000) |=> !irq);
endmodule

// File: tb/sim_evmon_unit.sv
module sim_evmon_unit;
  localparam int EW = 48;
  localparam int PS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [EW-1:0] evt = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evmon_unit #(.CNT_W(32), .EVT_W(EW), .PRESCALE(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .evt_in(evt), .irq(irq));

  // behavioural reference model
  bit          m_run, m_div;
  bit [2:0]    m_ien, m_ovf;
  int          m_s0, m_s1, m_pre;
  bit [31:0]   m_cyc, m_c0, m_c1;

  function automatic bit ev_hit(int code);
    return (code < EW) ? evt[code] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_div = 0; m_ien = 0; m_ovf = 0;
      m_s0 = 0; m_s1 = 0; m_pre = 0;
      m_cyc = 0; m_c0 = 0; m_c1 = 0;
    end else begin
      bit ctl, tk, h0, h1;
      bit [2:0] nov;
      ctl = we && addr == 0;
      tk  = m_run && (!m_div || m_pre == PS - 1);
      h0  = m_run && ev_hit(m_s0);
      h1  = m_run && ev_hit(m_s1);
      nov = m_ovf;
      if (ctl) nov = nov & ~wdata[10:8];
      if (ctl && wdata[2]) begin m_cyc = 0; m_pre = 0; end
      else begin
        if (m_run && m_div) m_pre = (m_pre + 1) % PS;
        if (we && addr == 1) m_cyc = wdata;
        else if (tk) begin
          if (m_cyc == 32'hFFFF_FFFF) nov[2] = 1;
          m_cyc = m_cyc + 1;
        end
      end
      if (ctl && wdata[1]) begin m_c0 = 0; m_c1 = 0; end
      else begin
        if (we && addr == 2) m_c0 = wdata;
        else if (h0) begin
          if (m_c0 == 32'hFFFF_FFFF) nov[0] = 1;
          m_c0 = m_c0 + 1;
        end
        if (we && addr == 3) m_c1 = wdata;
        else if (h1) begin
          if (m_c1 == 32'hFFFF_FFFF) nov[1] = 1;
          m_c1 = m_c1 + 1;
        end
      end
      m_ovf = nov;
      if (ctl) begin
        m_run = wdata[0]; m_div = wdata[3]; m_ien = wdata[6:4];
        m_s0 = int'(wdata[27:20]); m_s1 = int'(wdata[19:12]);
      end
    end
  end

  function automatic bit [31:0] m_read(bit [1:0] a);
    case (a)
      2'd0: return (32'(m_run)) | (32'(m_div) << 3) | (32'(m_ien) << 4) |
                   (32'(m_ovf) << 8) | (32'(m_s1) << 12) | (32'(m_s0) << 20);
      2'd1: return m_cyc;
      2'd2: return m_c0;
      default: return m_c1;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL model %s addr %0d actual %h expected %h",
                 (addr == 0) ? "R10" : (addr == 1) ? "R4" : "R3", addr, rdata, m_read(addr));
      end
      checks++;
      if (irq !== |(m_ovf & m_ien)) begin
        errors++;
        $display("FAIL model R9 irq actual %b expected %b", irq, |(m_ovf & m_ien));
      end
    end
  end

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input bit [1:0] a, input bit [31:0] exp, input string tag);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog R1 actual hung expected finished");
    finish_run();
  end

  localparam bit [31:0] CTL_A = 32'h0030_5001;
  localparam bit [31:0] CTL_B = 32'h020F_F001;

  initial begin
    bit [31:0] snap;
    idle(3);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 32'h0, "R1");
    irq_chk(1'b0, "R1");

    // R2 global enable clear: events ignored
    evt = '1;
    idle(5);
    rd_chk(2'd2, 32'h0, "R2");
    rd_chk(2'd3, 32'h0, "R2");
    rd_chk(2'd1, 32'h0, "R2");
    evt = '0;

    // R10 control readback, R3 event counting
    wr(2'd0, CTL_A);
    rd_chk(2'd0, CTL_A, "R10");
    evt[3] = 1; evt[5] = 1;
    idle(2);
    evt[5] = 0;
    idle(2);
    evt = '0;
    rd_chk(2'd2, 32'd4, "R3");
    rd_chk(2'd3, 32'd2, "R3");
    rd_chk(2'd1, 32'd4, "R4");

    // R6 cycle reset bit, R4 plain count
    wr(2'd0, CTL_A | 32'h4);
    rd_chk(2'd1, 32'd0, "R6");
    rd_chk(2'd0, CTL_A, "R6");
    idle(10);
    rd_chk(2'd1, 32'd10, "R4");

    // R4 prescaled count
    wr(2'd0, CTL_A | 32'hC);
    idle(20);
    rd_chk(2'd1, 32'd2, "R4");
    idle(4);
    rd_chk(2'd1, 32'd3, "R4");
    wr(2'd0, CTL_A);

    // R3 idle trace code and unmatched code
    wr(2'd0, CTL_B);
    evt = ~(48'd1 << 32);
    idle(6);
    rd_chk(2'd2, 32'd4, "R3");
    rd_chk(2'd3, 32'd2, "R3");
    evt = '0;

    // R5 load wins over increment
    wr(2'd0, CTL_A);
    evt[3] = 1;
    wr(2'd2, 32'hFFFF_FFFE);
    evt = '0;
    rd_chk(2'd2, 32'hFFFF_FFFE, "R5");

    // R7 wrap sets flag
    evt[3] = 1;
    idle(2);
    evt = '0;
    rd_chk(2'd2, 32'h0, "R7");
    rd_chk(2'd0, 32'h0030_5101, "R7");
    irq_chk(1'b0, "R9");

    // R9 enable, R8 hold and clear
    wr(2'd0, CTL_A | 32'h10);
    irq_chk(1'b1, "R9");
    idle(3);
    rd_chk(2'd0, 32'h0030_5111, "R8");
    wr(2'd0, CTL_A | 32'h110);
    irq_chk(1'b0, "R9");
    rd_chk(2'd0, 32'h0030_5011, "R8");

    // R7 cycle counter wrap, R9 its enable
    wr(2'd1, 32'hFFFF_FFFD);
    idle(3);
    rd_chk(2'd1, 32'h0, "R7");
    rd_chk(2'd0, 32'h0030_5411, "R7");
    irq_chk(1'b0, "R9");
    wr(2'd0, CTL_A | 32'h40);
    irq_chk(1'b1, "R9");

    // R6 event counter reset bit
    wr(2'd0, CTL_A | 32'h2);
    rd_chk(2'd2, 32'h0, "R6");
    rd_chk(2'd3, 32'h0, "R6");
    rd_chk(2'd0, 32'h0030_5401, "R6");

    // R2 stop again: all quiet
    wr(2'd0, 32'h0030_5000);
    addr = 2'd1; #1; snap = rdata;
    evt = '1;
    idle(5);
    rd_chk(2'd1, snap, "R2");
    rd_chk(2'd2, 32'h0, "R2");
    evt = '0;

    idle(2);
    finish_run();
  end
endmodule